// File: doc/BRIEF.md
# Dithered Two-Channel PWM Generator

This block drives a set of pulse-width modulated pins from 8-bit duty values. A single free-running counter of `DUTY_W` bits defines a modulation period of 256 clocks. The period is split into equal sub-cycles. Each sub-cycle produces a pulse whose high time is the coarse part of the duty value. The fine part of the duty value then adds one extra high clock to the first few sub-cycles. The average duty over a full period therefore has the full 8-bit resolution. The counter behind each pulse is narrower than the duty value, so each pulse repeats at a higher rate, and that ripple is easier for an external filter to remove.

A shared mode pin selects how the duty value is split. In four-way mode there are four sub-cycles of 64 clocks, with six coarse bits and two fine bits. In two-way mode there are two sub-cycles of 128 clocks, with seven coarse bits and one fine bit. Each channel has its own duty value and enable. When a channel is disabled, its pin carries a plain general-purpose data bit, so the pin works as ordinary I/O.

A duty value and the mode are sampled at period boundaries. A period that has started always runs to completion with the values it started with. The pins are plain registered outputs. There is no handshake, because the block consumes levels, not a stream of data.

Top module: `dpwm_gen`

## Requirements
- R1: While `rst_i` is high, and on the first clock after it falls, every `pwm_o` bit is 0. The period counter restarts at the beginning of a period when reset is released.
- R2: While `en_i[c]` is 0, `pwm_o[c]` equals the value `io_i[c]` had at the previous rising clock edge.
- R3: With `mode_i` = 1 (two-way mode), the coarse value is duty bits 7..1 and the fine value is bit 0. There are two sub-cycles of 128 clocks each. Sub-cycle k is high for coarse+1 clocks when k is less than the fine value, and for coarse clocks otherwise. The high clocks come first in each sub-cycle.
- R4: With `mode_i` = 0 (four-way mode), the coarse value is duty bits 7..2 and the fine value is bits 1..0. There are four sub-cycles of 64 clocks each, and the same rule for extra high clocks applies.
- R5: A duty value of 0 on an enabled channel keeps its pin low for the whole period.
- R6: A new duty value on an enabled channel is used only from the start of the next 256-clock period. A disabled channel picks up its duty value on every clock.
- R7: A change of `mode_i` takes effect only at the start of the next 256-clock period.
- R8: In both modes, the number of high clocks in any 256 consecutive clocks with a steady duty value equals that duty value.
- R9: Each channel's pin depends only on its own duty value, enable and I/O bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0 selects four-way (6+2) mode, 1 selects two-way (7+1) mode |
| duty_i | input | NUM_CH*DUTY_W | Duty values. Channel c uses bits [c*DUTY_W +: DUTY_W] |
| en_i | input | NUM_CH | Per-channel PWM enable |
| io_i | input | NUM_CH | General-purpose data bits shown on disabled pins |
| pwm_o | output | NUM_CH | Registered PWM or I/O pin levels |

## Verification
The bench builds the block with its defaults: two channels and 8-bit duty values, which give a 256-clock period with 64- and 128-clock sub-cycles. A few hundred clocks are therefore enough to cover complete periods in both modes. They also reach the extreme duty values 0, 1 and 255, where the fine part fills all but one sub-cycle. Two channels are enough to show that the channels are independent while the period counter and mode latch are shared.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic {
    MODE_QUAD = 1'b0,
    MODE_PAIR = 1'b1
  } dpwm_mode_e;
endpackage

// File: rtl/dpwm_period_ctr.sv
module dpwm_period_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == TOP);
endmodule

// File: rtl/dpwm_shadow.sv
module dpwm_shadow #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk_i) begin
    if (rst_i)       q_r <= '0;
    else if (load_i) q_r <= d_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/dpwm_slice.sv
module dpwm_slice
  import dpwm_pkg::*;
#(
  parameter int W       = 8,
  parameter int FRAC_LO = 2,
  parameter int FRAC_HI = 1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] cnt_i,
  input  dpwm_mode_e   mode_i,
  input  logic [W-1:0] duty_i,
  input  logic         en_i,
  input  logic         io_i,
  output logic         pin_o
);
  logic [1:0] lvl_v;

  for (genvar v = 0; v < 2; v++) begin : g_variant
    localparam int FR  = (v == 0) ? FRAC_LO : FRAC_HI;
    localparam int SBW = W - FR;

    logic [W-1:0] pos, sub, dc, ac;

    assign pos = {{FR{1'b0}},  cnt_i[SBW-1:0]};
    assign sub = {{SBW{1'b0}}, cnt_i[W-1:SBW]};
    assign dc  = {{FR{1'b0}},  duty_i[W-1:FR]};
    assign ac  = {{SBW{1'b0}}, duty_i[FR-1:0]};

    assign lvl_v[v] = (pos < dc) || ((pos == dc) && (sub < ac));
  end

  logic lvl;
  assign lvl = (mode_i == MODE_PAIR) ? lvl_v[1] : lvl_v[0];

  logic pin_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) pin_q <= 1'b0;
    else       pin_q <= en_i ? lvl : io_i;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
  import dpwm_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int DUTY_W  = 8,
  parameter int FRAC_LO = 2,
  parameter int FRAC_HI = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       mode_i,
  input  logic [NUM_CH*DUTY_W-1:0]   duty_i,
  input  logic [NUM_CH-1:0]          en_i,
  input  logic [NUM_CH-1:0]          io_i,
  output logic [NUM_CH-1:0]          pwm_o
);
  logic [DUTY_W-1:0]        cnt_q;
  logic                     at_last;
  dpwm_mode_e               mode_q;
  logic [NUM_CH*DUTY_W-1:0] act_flat;

  dpwm_period_ctr #(.W(DUTY_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .cnt_o  (cnt_q),
    .last_o (at_last)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)        mode_q <= MODE_QUAD;
    else if (at_last) mode_q <= dpwm_mode_e'(mode_i);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DUTY_W-1:0] act;

    dpwm_shadow #(.W(DUTY_W)) u_shadow (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (at_last | ~en_i[c]),
      .d_i    (duty_i[c*DUTY_W +: DUTY_W]),
      .q_o    (act)
    );

    assign act_flat[c*DUTY_W +: DUTY_W] = act;

    dpwm_slice #(.W(DUTY_W), .FRAC_LO(FRAC_LO), .FRAC_HI(FRAC_HI)) u_slice (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .cnt_i  (cnt_q),
      .mode_i (mode_q),
      .duty_i (act),
      .en_i   (en_i[c]),
      .io_i   (io_i[c]),
      .pin_o  (pwm_o[c])
    );
  end
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
  parameter int NUM_CH = 2,
  parameter int DUTY_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_i,
  input logic                     mode_i,
  input logic [NUM_CH-1:0]        en_i,
  input logic [NUM_CH-1:0]        io_i,
  input logic [NUM_CH-1:0]        pwm_o,
  input logic [DUTY_W-1:0]        cnt_i,
  input logic                     mode_q_i,
  input logic [NUM_CH*DUTY_W-1:0] act_i
);
  localparam logic [DUTY_W-1:0] TOP = {DUTY_W{1'b1}};

  assert_cnt_step_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> cnt_i == $past(cnt_i) + 1'b1);

  assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_i != TOP) |=> (mode_q_i == $past(mode_q_i)));

  assert_mode_take_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_i == TOP) |=> (mode_q_i == $past(mode_i)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_io_pass_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i[c] |=> (pwm_o[c] == $past(io_i[c])));

    assert_duty_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i[c] && cnt_i != TOP) |=> $stable(act_i[c*DUTY_W +: DUTY_W]));

    assert_zero_low_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i[c] && act_i[c*DUTY_W +: DUTY_W] == '0) |=> !pwm_o[c]);
  end
endmodule

bind dpwm_gen dpwm_checker #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .mode_i   (mode_i),
  .en_i     (en_i),
  .io_i     (io_i),
  .pwm_o    (pwm_o),
  .cnt_i    (cnt_q),
  .mode_q_i (mode_q),
  .act_i    (act_flat)
);

// File: tb/sim_dpwm_gen.sv
`timescale 1ns/1ps
module sim_dpwm_gen;
  localparam int NC = 2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode = 1'b0;
  logic [NC*DW-1:0] duty = '0;
  logic [NC-1:0] en = '0;
  logic [NC-1:0] io = '0;
  logic [NC-1:0] pwm;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dpwm_gen #(.NUM_CH(NC), .DUTY_W(DW)) u0 (
    .clk_i(clk), .rst_i(rst), .mode_i(mode), .duty_i(duty),
    .en_i(en), .io_i(io), .pwm_o(pwm)
  );

  // Independent requirement model
  logic [7:0] m_cnt;
  logic       m_mode;
  logic [7:0] m_act [NC];
  logic       m_exp [NC];

  function automatic bit lvl(input logic [7:0] cnt, input logic [7:0] d, input logic md);
    int sublen = md ? 128 : 64;
    int fb     = md ? 1 : 2;
    int coarse = d >> fb;
    int fine   = d & ((1 << fb) - 1);
    int k      = cnt / sublen;
    int p      = cnt % sublen;
    int hi     = coarse + ((k < fine) ? 1 : 0);
    return p < hi;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt  <= 0;
      m_mode <= 0;
      for (int c = 0; c < NC; c++) begin
        m_act[c] <= 0;
        m_exp[c] <= 0;
      end
    end else begin
      for (int c = 0; c < NC; c++) begin
        m_exp[c] <= en[c] ? lvl(m_cnt, m_act[c], m_mode) : io[c];
        if (m_cnt == 8'hFF || !en[c]) m_act[c] <= duty[c*DW +: DW];
      end
      if (m_cnt == 8'hFF) m_mode <= mode;
      m_cnt <= m_cnt + 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        string t = en[c] ? tag : "R2";
        check(pwm[c] === m_exp[c], $sformatf("%s ch%0d", t, c), pwm[c], m_exp[c]);
      end
    end
  endtask

  task automatic count_high(input int c, input int expd, input string tag);
    int hi = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm[c] === 1'b1) hi++;
    end
    check(hi == expd, $sformatf("%s high count ch%0d", tag, c), hi, expd);
  endtask

  task automatic steady(input bit md, input int d0, input int d1, input string tag);
    @(negedge clk);
    mode = md;
    duty = {8'(d1), 8'(d0)};
    en   = 2'b11;
    run(600, tag);
    count_high(0, d0, tag);
    count_high(1, d1, "R9");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pwm === 2'b00, "R1 in reset", pwm, 0);
    en = 2'b11; duty = 16'hFFFF;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm === 2'b00, "R1 first clock", pwm, 0);
    run(300, "R1");

    // Directed corners
    steady(1'b0, 255, 1,   "R8");
    steady(1'b1, 255, 130, "R8");
    steady(1'b0, 0,   77,  "R5");
    steady(1'b1, 1,   0,   "R5");
    steady(1'b0, 6,   200, "R4");
    steady(1'b1, 7,   64,  "R3");

    // R6: duty changed mid-period, R7: mode changed mid-period
    @(negedge clk); duty = 16'h3C81; run(97, "R6");
    @(negedge clk); duty = 16'hC317; run(300, "R6");
    @(negedge clk); mode = ~mode; run(131, "R7");
    @(negedge clk); mode = ~mode; run(300, "R7");

    // R2: disabled channels show I/O data
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      en = 2'b00; io = 2'($urandom);
      run(1, "R2");
    end

    // Random mix
    for (int t = 0; t < 120; t++) begin
      @(negedge clk);
      mode = 1'($urandom);
      duty = 16'($urandom);
      en   = 2'($urandom);
      io   = 2'($urandom);
      run(50 + ($urandom % 300), mode ? "R3" : "R4");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule